// File: doc/BRIEF.md
# Output Clock Divider with Phase Slip

This block turns the converter's sample clock into the output data clock. It produces a per-cycle enable, `clkEn`. The enable is high in every sample-clock cycle that carries a rising edge of the output clock, and downstream clock gating uses it. The output runs at the full sample rate or at half of it, as the resolved divide select chooses.

A register-side control bit requests a phase slip. The request counts only when the bit goes from 0 to 1. At half rate, a slip shifts the output clock's rising edge by one sample period, modulo the two-period output cycle. The shift is made by holding the low phase for one extra input cycle, so no phase ever becomes shorter than one input period. Slips add up. At full rate, a slip is acknowledged but the output does not change. A one-cycle `slipDone` pulse marks the adjusted edge.

The control bit comes from another clock domain and passes through a multi-stage synchronizer before edge detection. A change of ratio is held until the next output rising edge.

Top module: `oclk_div_slip`

## Requirements
- R1: While `rstN` is low, `clkEn` and `slipDone` are both 0.
- R2: With `divSel` = 0 (ratio one), `clkEn` is 1 in every input cycle once the ratio is in effect.
- R3: With `divSel` = 1 (ratio two), and with no slip pending, `clkEn` pulses are exactly two input cycles apart and are never high in two consecutive cycles.
- R4: A new `divSel` value takes effect only in a cycle where `clkEn` rises. At ratio two, changing `divSel` to 0 in the cycle right after a pulse still leaves the next cycle low.
- R5: A slip is requested only by a 0-to-1 change of `slipBit` as seen after the synchronizer. A bit held at 1 through reset, rewritten at 1, or lowered from 1 to 0 requests nothing.
- R6: At ratio two, each slip makes exactly one gap of three input cycles between consecutive `clkEn` pulses. This moves the output edge by one input period, and the parity of the pulse cycles flips.
- R7: Slips accumulate. Two separate slips give two gaps of three, and the pulse parity returns to where it was before them.
- R8: At ratio one, a slip is acknowledged with `slipDone`, and `clkEn` stays high every cycle.
- R9: Each accepted slip gives exactly one `slipDone` pulse, one cycle wide. It falls in the same cycle as the adjusted `clkEn` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| divSel | input | 1 | Resolved divide select: 0 = ratio one, 1 = ratio two |
| slipBit | input | 1 | Phase-slip control bit from the register domain (asynchronous) |
| clkEn | output | 1 | Output clock rising-edge enable, one per output period |
| slipDone | output | 1 | One-cycle acknowledge on the adjusted edge |

## Verification
The assertions assume the following about the inputs:
- Successive 0-to-1 changes of `slipBit` are far enough apart that each is taken before the next arrives.
- Each level of `slipBit` is held for more cycles than the synchronizer depth.
- `divSel` is stable whenever a check of the pulse spacing depends on it.

The stimulus keeps within these limits as follows:
- It spaces every raise and every lower of the slip bit by at least eight input cycles.
- It leaves gap checking off for a few cycles around each ratio change, and turns it back on only after the new ratio has settled.
- For the ratio-change timing, it checks the exact cycles directly instead of relying on the gap monitor.

// File: rtl/oclk_div_pkg.sv
package oclk_div_pkg;

  typedef enum logic {
    RATIO_ONE = 1'b0,
    RATIO_TWO = 1'b1
  } ratio_e;

  // strobes from control to datapath, one set per input cycle
  typedef struct packed {
    logic riseStb;   // output clock rises in the coming cycle
    logic doneStb;   // that rise is the slip-adjusted edge
  } ctrl_stb_t;

endpackage

// File: rtl/oclk_slip_sync.sv
module oclk_slip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  output logic edgeOut
);

  logic [STAGES-1:0] chainQ;
  logic              lastQ;

  initial begin
    stages_min_chk: assert (STAGES >= 2)
      else $error("synchronizer needs at least two stages");
  end

  // flops reset to 1 so a bit already high at reset is not seen as a rise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainQ <= '1;
      lastQ  <= 1'b1;
    end else begin
      chainQ <= {chainQ[STAGES-2:0], bitIn};
      lastQ  <= chainQ[STAGES-1];
    end
  end

  assign edgeOut = chainQ[STAGES-1] & ~lastQ;

endmodule

// File: rtl/oclk_div_ctrl.sv
module oclk_div_ctrl
  import oclk_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      slipEdge,
  input  logic      enQ,
  input  ratio_e    modeQ,
  output ctrl_stb_t stb
);

  logic pendQ;
  logic adjQ;
  logic holdNow;
  logic riseNow;

  // take a pending slip: at ratio one at once, at ratio two only in a
  // low cycle that would otherwise be followed by a rise
  always_comb begin
    holdNow = pendQ && !adjQ && ((modeQ == RATIO_ONE) || !enQ);
    if (modeQ == RATIO_ONE) begin
      riseNow = 1'b1;
    end else begin
      riseNow = !enQ && !holdNow;
    end
    stb.riseStb = riseNow;
    stb.doneStb = riseNow && adjQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      adjQ  <= 1'b0;
    end else begin
      if (slipEdge) begin
        pendQ <= 1'b1;
      end else if (holdNow) begin
        pendQ <= 1'b0;
      end
      if (holdNow) begin
        adjQ <= 1'b1;
      end else if (riseNow) begin
        adjQ <= 1'b0;
      end
    end
  end

  // R5
  pend_from_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(slipEdge))
    else $error("slip pending without a synchronized rise");

  // R2
  div1_every_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == RATIO_ONE && enQ) |=> enQ)
    else $error("ratio one missed an output edge");

endmodule

// File: rtl/oclk_div_dp.sv
module oclk_div_dp
  import oclk_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      divSel,
  input  ctrl_stb_t stb,
  output logic      enQ,
  output ratio_e    modeQ,
  output logic      doneQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      modeQ <= RATIO_ONE;
      doneQ <= 1'b0;
    end else begin
      enQ   <= stb.riseStb;
      doneQ <= stb.doneStb;
      if (stb.riseStb) begin
        modeQ <= ratio_e'(divSel);
      end
    end
  end

  // R3
  div2_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == RATIO_TWO && enQ) |=> !enQ)
    else $error("ratio two produced consecutive edges");

  // R4
  ratio_at_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeQ) |-> enQ)
    else $error("ratio changed away from an output edge");

  // R9
  done_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> enQ)
    else $error("slip acknowledge off the output edge");

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ)
    else $error("slip acknowledge wider than one cycle");

endmodule

// File: rtl/oclk_div_slip.sv
module oclk_div_slip
  import oclk_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic divSel,
  input  logic slipBit,
  output logic clkEn,
  output logic slipDone
);

  logic      slipEdge;
  logic      enQ;
  ratio_e    modeQ;
  logic      doneQ;
  ctrl_stb_t stb;

  oclk_slip_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .bitIn   (slipBit),
    .edgeOut (slipEdge)
  );

  oclk_div_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .slipEdge (slipEdge),
    .enQ      (enQ),
    .modeQ    (modeQ),
    .stb      (stb)
  );

  oclk_div_dp dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .divSel (divSel),
    .stb    (stb),
    .enQ    (enQ),
    .modeQ  (modeQ),
    .doneQ  (doneQ)
  );

  assign clkEn    = enQ;
  assign slipDone = doneQ;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rstN) |-> (!clkEn && !slipDone))
    else $error("outputs active after reset");

endmodule

// File: tb/oclk_div_slip_tb_top.sv
module oclk_div_slip_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic divSel;
  logic slipBit;
  logic clkEn;
  logic slipDone;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int lastCyc = -1;
  int expGap  = 1;
  bit chkOn   = 1'b0;
  bit finished = 1'b0;
  int slipQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  oclk_div_slip dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .divSel   (divSel),
    .slipBit  (slipBit),
    .clkEn    (clkEn),
    .slipDone (slipDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sampleEdge();
    @(posedge clk);
    #1;
  endtask

  // monitor: pops expected slip gaps as acknowledges appear
  initial begin
    forever begin
      sampleEdge();
      if (rstN) begin
        cyc++;
        if (slipDone) begin
          check(clkEn == 1'b1, "R9 ack on edge", clkEn, 1);
          if (slipQ.size() == 0) begin
            check(1'b0, "R5 unexpected slip ack", 1, 0);
          end else begin
            int e;
            e = slipQ.pop_front();
            if (chkOn && lastCyc >= 0)
              check(cyc - lastCyc == e, "R6/R8 slip gap", cyc - lastCyc, e);
          end
        end else if (clkEn && chkOn && lastCyc >= 0) begin
          check(cyc - lastCyc == expGap,
                expGap == 1 ? "R2 ratio one gap" : "R3 ratio two gap",
                cyc - lastCyc, expGap);
        end
        if (clkEn) lastCyc = cyc;
      end
    end
  end

  task automatic slipRaise(input int expG);
    @(negedge clk);
    slipQ.push_back(expG);
    slipBit = 1'b1;
    waitCyc(14);
  endtask

  task automatic slipLower();
    @(negedge clk);
    slipBit = 1'b0;
    waitCyc(8);
  endtask

  initial begin
    int p0;
    rstN = 1'b0;
    divSel = 1'b0;
    slipBit = 1'b1;
    waitCyc(4);
    check(clkEn == 1'b0, "R1 clkEn in reset", clkEn, 0);
    check(slipDone == 1'b0, "R1 slipDone in reset", slipDone, 0);

    // ratio one; bit held at 1 through reset must not slip (R5)
    @(negedge clk); rstN = 1'b1;
    waitCyc(4);
    expGap = 1; chkOn = 1'b1;
    waitCyc(20);
    check(slipQ.size() == 0, "R5 no slip from reset level", slipQ.size(), 0);

    // R5: rewriting 1 does nothing
    @(negedge clk); slipBit = 1'b1;
    waitCyc(10);

    // R8: slip at ratio one
    slipLower();
    slipRaise(1);
    check(slipQ.size() == 0, "R8 slip acknowledged", slipQ.size(), 0);
    check(clkEn == 1'b1, "R8 clkEn still high", clkEn, 1);

    // R3: ratio two
    @(negedge clk); chkOn = 1'b0; divSel = 1'b1;
    waitCyc(6);
    expGap = 2; chkOn = 1'b1;
    waitCyc(20);

    // R5: lowering alone does not slip
    p0 = lastCyc % 2;
    slipLower();
    check(lastCyc % 2 == p0, "R5 lowering keeps phase", lastCyc % 2, p0);

    // R6: one slip flips pulse parity
    p0 = lastCyc % 2;
    slipRaise(3);
    check(slipQ.size() == 0, "R6 slip taken", slipQ.size(), 0);
    check(lastCyc % 2 == 1 - p0, "R6 phase advanced", lastCyc % 2, 1 - p0);

    // R7: two slips restore parity
    p0 = lastCyc % 2;
    slipLower();
    slipRaise(3);
    slipLower();
    slipRaise(3);
    check(slipQ.size() == 0, "R7 both slips taken", slipQ.size(), 0);
    check(lastCyc % 2 == p0, "R7 accumulated phase", lastCyc % 2, p0);

    // R4: ratio change waits for next rising edge
    chkOn = 1'b0;
    do sampleEdge(); while (!clkEn);
    @(negedge clk); divSel = 1'b0;
    sampleEdge();
    check(clkEn == 1'b0, "R4 no early edge", clkEn, 0);
    sampleEdge();
    check(clkEn == 1'b1, "R4 edge on schedule", clkEn, 1);
    sampleEdge();
    check(clkEn == 1'b1, "R4 ratio one in effect", clkEn, 1);
    @(negedge clk); expGap = 1; chkOn = 1'b1;
    waitCyc(12);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule